// File: doc/BRIEF.md
# On-Screen-Display Raster Window Generator

This block locates the character overlay of an on-screen display inside the incoming video raster. A dot counter runs on the display dot clock from the moment the line sync enters its selected run level and is cleared as soon as the sync leaves that level. A line counter advances on every line sync pulse and is held at zero while the frame sync sits at its selected clear level. Two 6-bit position values place the top-left corner of the first character. The horizontal start lies four dot clocks per step plus a fixed offset of five after the sync. The vertical start lies four scan lines per step.

Inside the window the block reports two things. One is whether the current dot lies in the character area. The other is whether the current scan line lies in a character row. It also reports the dot column inside the 12-dot-wide cell, the line inside the 18-line-tall cell, and the index of the character row. A per-row size code stretches each dot over 1 to 4 clocks and 1 to 4 lines. A gap code inserts blank scan lines between rows. Downstream font, colour and memory logic use these indices to fetch and paint pixels.

Top module: `osd_raster_timer`

## Requirements
- R1: While reset is asserted and just after it is released, hActive, vActive, dotCol, cellLine and charRow are all zero.
- R2: With hsyncIn entering its run level just before a rising edge, hActive is first high after the (4*hStart+8)th rising edge counted from that edge. This is two synchronizer stages plus a count of 4*hStart+5 plus one output register.
- R3: hActive stays high for exactly COLS*12*s clocks, where s = rowSize+1 is the scale of the current row. During that time dotCol runs 0,1,...,11 and repeats, holding each value for s clocks.
- R4: hRunHigh=1 makes the high level of hsyncIn the run level, and hRunHigh=0 makes the low level the run level. Timing is the same for both.
- R5: When hsyncIn leaves the run level, the dot counter and the horizontal window are cleared. hActive and dotCol read zero after the third rising edge.
- R6: Line sync pulses after the frame sync leaves its clear level are numbered from 0. The character area begins on pulse number 4*vStart, with vActive=1, cellLine=0 and charRow=0.
- R7: Each character row occupies 18*s consecutive lines, with cellLine = (line within row)/s. charRow counts rows 0 to ROWS-1, and the window closes after the last row.
- R8: rowGap codes 0,1,2,3 insert 0,4,8,12 blank lines between consecutive rows, and none after the last row. During the gap vActive, cellLine and charRow are zero.
- R9: vClrHigh=1 makes the high level of vsyncIn clear the line counter and the vertical window, and vClrHigh=0 makes the low level do so.
- R10: rowSize (code 0..3 = scale 1..4) is sampled at the first line of each row. A change during a row takes effect at the next row, for both directions.
- R11: With enable low, both counters are held at zero and every output stays zero regardless of the sync inputs.
- R12: dotCol is zero whenever hActive is low. cellLine and charRow are zero whenever vActive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the counters when high |
| hsyncIn | input | 1 | Line sync, asynchronous |
| vsyncIn | input | 1 | Frame sync, asynchronous |
| hRunHigh | input | 1 | 1: dot counter runs while hsyncIn is high; 0: while low |
| vClrHigh | input | 1 | 1: vsyncIn high clears the line counter; 0: low clears it |
| hStart | input | POS_W | Horizontal start step (4 dots each, plus 5) |
| vStart | input | POS_W | Vertical start step (4 lines each) |
| rowSize | input | 2 | Scale code 0..3 for scale 1..4, sampled per row |
| rowGap | input | 2 | Blank lines between rows: code*4 |
| hActive | output | 1 | Dot lies in the character columns |
| vActive | output | 1 | Line lies in a character row |
| dotCol | output | 4 | Dot column in cell, 0..11 |
| cellLine | output | 5 | Line in cell, 0..17 |
| charRow | output | ROW_IDX_W | Character row index |

## Verification
The horizontal results come from a three-register path: two synchronizer stages, then the dot counter, then the window register. As a result, hActive is due 4*hStart+8 edges after the sync change and clears three edges after the sync leaves its run level. The bench changes inputs on falling edges and counts falling-edge samples from the change, comparing the first-high sample, the width and every dotCol value against those counts. The vertical state updates on the third edge after a line pulse begins. The bench makes each line four clocks long and samples at its end, so every vertical result is compared one full line after the pulse that caused it.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;

  localparam int CELL_W = 12;
  localparam int CELL_H = 18;
  localparam int DOT_W  = 4;
  localparam int LINE_W = 5;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic hRun;    // dot counter may run this clock
    logic hEdge;   // one-clock pulse at the start of a line
    logic vClear;  // hold line counter and vertical window at zero
  } osdStrobe_t;

endpackage

// File: rtl/osd_raster_ctrl.sv
module osd_raster_ctrl
  import osd_raster_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       hsyncIn,
  input  logic       vsyncIn,
  input  logic       hRunHigh,
  input  logic       vClrHigh,
  output osdStrobe_t stb
);

  // [0],[1] synchronize; [2] keeps the previous synchronized level
  logic [2:0] hPipe;
  logic [1:0] vPipe;
  logic       hLvl;
  logic       hLvlPrev;
  logic       vLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPipe <= '0;
      vPipe <= '0;
    end else begin
      hPipe <= {hPipe[1:0], hsyncIn};
      vPipe <= {vPipe[0], vsyncIn};
    end
  end

  // fold the polarity select into a normalized level
  assign hLvl     = hPipe[1] ~^ hRunHigh;
  assign hLvlPrev = hPipe[2] ~^ hRunHigh;
  assign vLvl     = vPipe[1] ~^ vClrHigh;

  always_comb begin
    stb.hRun   = enable & hLvl;
    stb.hEdge  = enable & hLvl & ~hLvlPrev;
    stb.vClear = ~enable | vLvl;
  end

  // a line-start pulse lasts one clock while the polarity select is steady
  assert_edge_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.hEdge |=> (!stb.hEdge || !$stable(hRunHigh)))
    else $error("line start pulse longer than one clock");

endmodule

// File: rtl/osd_raster_dpath.sv
module osd_raster_dpath
  import osd_raster_pkg::*;
#(
  parameter int COLS      = 16,
  parameter int ROWS      = 10,
  parameter int POS_W     = 6,
  parameter int H_CNT_W   = 12,
  parameter int V_CNT_W   = 10,
  parameter int ROW_IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  osdStrobe_t           stb,
  input  logic [POS_W-1:0]     hStart,
  input  logic [POS_W-1:0]     vStart,
  input  logic [1:0]           rowSize,
  input  logic [1:0]           rowGap,
  output logic                 hActive,
  output logic                 vActive,
  output logic [DOT_W-1:0]     dotCol,
  output logic [LINE_W-1:0]    cellLine,
  output logic [ROW_IDX_W-1:0] charRow
);

  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [DOT_W-1:0]     DOT_LAST  = DOT_W'(CELL_W - 1);
  localparam logic [LINE_W-1:0]    LINE_LAST = LINE_W'(CELL_H - 1);
  localparam logic [COL_W-1:0]     COL_LAST  = COL_W'(COLS - 1);
  localparam logic [ROW_IDX_W-1:0] ROW_LAST  = ROW_IDX_W'(ROWS - 1);

  logic [H_CNT_W-1:0]   hCnt;
  logic [V_CNT_W-1:0]   vCnt;
  logic [H_CNT_W-1:0]   hStartDots;
  logic [V_CNT_W-1:0]   vStartLines;

  logic                 hActiveR;
  logic [DOT_W-1:0]     dotColR;
  logic [1:0]           hPre;
  logic [COL_W-1:0]     colIdx;

  logic                 vWin;
  logic                 vActiveR;
  logic                 inGap;
  logic [1:0]           vPre;
  logic [LINE_W-1:0]    lineR;
  logic [ROW_IDX_W-1:0] rowIdx;
  logic [3:0]           gapCnt;
  logic [1:0]           gapSelR;
  logic [1:0]           rowScaleM1;
  logic [3:0]           gapLast;

  assign hStartDots  = H_CNT_W'({hStart, 2'b00}) + H_CNT_W'(5);
  assign vStartLines = V_CNT_W'({vStart, 2'b00});
  assign gapLast     = {gapSelR, 2'b00} - 4'd1;

  // dot counter: runs during the run level, saturates at its top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               hCnt <= '0;
    else if (!stb.hRun)      hCnt <= '0;
    else if (hCnt != '1)     hCnt <= hCnt + 1'b1;
  end

  // line counter: one step per line start, held by the frame sync
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         vCnt <= '0;
    else if (stb.vClear)               vCnt <= '0;
    else if (stb.hEdge && vCnt != '1)  vCnt <= vCnt + 1'b1;
  end

  // horizontal window: prescaler, dot column, character column
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hActiveR <= 1'b0;
      dotColR  <= '0;
      hPre     <= '0;
      colIdx   <= '0;
    end else if (!stb.hRun) begin
      hActiveR <= 1'b0;
      dotColR  <= '0;
      hPre     <= '0;
      colIdx   <= '0;
    end else if (!hActiveR) begin
      if (hCnt == hStartDots) begin
        hActiveR <= 1'b1;
        dotColR  <= '0;
        hPre     <= '0;
        colIdx   <= '0;
      end
    end else if (hPre != rowScaleM1) begin
      hPre <= hPre + 2'd1;
    end else begin
      hPre <= '0;
      if (dotColR != DOT_LAST) begin
        dotColR <= dotColR + 1'b1;
      end else begin
        dotColR <= '0;
        if (colIdx == COL_LAST) hActiveR <= 1'b0;
        else                    colIdx   <= colIdx + 1'b1;
      end
    end
  end

  // vertical window: line prescaler, cell line, row index, row gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vWin       <= 1'b0;
      vActiveR   <= 1'b0;
      inGap      <= 1'b0;
      vPre       <= '0;
      lineR      <= '0;
      rowIdx     <= '0;
      gapCnt     <= '0;
      gapSelR    <= '0;
      rowScaleM1 <= '0;
    end else if (stb.vClear) begin
      vWin       <= 1'b0;
      vActiveR   <= 1'b0;
      inGap      <= 1'b0;
      vPre       <= '0;
      lineR      <= '0;
      rowIdx     <= '0;
      gapCnt     <= '0;
      gapSelR    <= '0;
      rowScaleM1 <= '0;
    end else if (stb.hEdge) begin
      if (!vWin) begin
        if (vCnt == vStartLines) begin
          vWin       <= 1'b1;
          vActiveR   <= 1'b1;
          inGap      <= 1'b0;
          vPre       <= '0;
          lineR      <= '0;
          rowIdx     <= '0;
          gapSelR    <= rowGap;
          rowScaleM1 <= rowSize;
        end
      end else if (inGap) begin
        if (gapCnt == gapLast) begin
          inGap      <= 1'b0;
          vActiveR   <= 1'b1;
          rowIdx     <= rowIdx + 1'b1;
          lineR      <= '0;
          vPre       <= '0;
          rowScaleM1 <= rowSize;
        end else begin
          gapCnt <= gapCnt + 4'd1;
        end
      end else if (vPre != rowScaleM1) begin
        vPre <= vPre + 2'd1;
      end else begin
        vPre <= '0;
        if (lineR != LINE_LAST) begin
          lineR <= lineR + 1'b1;
        end else begin
          lineR <= '0;
          if (rowIdx == ROW_LAST) begin
            vWin     <= 1'b0;
            vActiveR <= 1'b0;
            rowIdx   <= '0;
          end else if (gapSelR == 2'd0) begin
            rowIdx     <= rowIdx + 1'b1;
            rowScaleM1 <= rowSize;
          end else begin
            inGap    <= 1'b1;
            vActiveR <= 1'b0;
            gapCnt   <= '0;
          end
        end
      end
    end
  end

  assign hActive  = hActiveR;
  assign dotCol   = dotColR;
  assign vActive  = vActiveR;
  assign cellLine = vActiveR ? lineR  : '0;
  assign charRow  = vActiveR ? rowIdx : '0;

  assert_dot_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    hActive |-> (dotCol < DOT_W'(CELL_W)))
    else $error("dot column out of cell");

  assert_dot_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hActive && $past(hActive)) |->
      (dotCol == $past(dotCol) || dotCol == $past(dotCol) + 1'b1 || dotCol == '0))
    else $error("dot column skipped a value");

  assert_line_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    vActive |-> (cellLine < LINE_W'(CELL_H)))
    else $error("cell line out of cell");

  assert_h_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.hRun |=> (hCnt == '0 && !hActive))
    else $error("dot counter not cleared outside run level");

  assert_v_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.vClear |=> (vCnt == '0 && !vActive))
    else $error("line counter not cleared by frame sync");

  assert_gap_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    inGap |-> !vActive)
    else $error("row gap shows as active");

endmodule

// File: rtl/osd_raster_timer.sv
module osd_raster_timer
  import osd_raster_pkg::*;
#(
  parameter int COLS      = 16,
  parameter int ROWS      = 10,
  parameter int POS_W     = 6,
  parameter int H_CNT_W   = 12,
  parameter int V_CNT_W   = 10,
  parameter int ROW_IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 hsyncIn,
  input  logic                 vsyncIn,
  input  logic                 hRunHigh,
  input  logic                 vClrHigh,
  input  logic [POS_W-1:0]     hStart,
  input  logic [POS_W-1:0]     vStart,
  input  logic [1:0]           rowSize,
  input  logic [1:0]           rowGap,
  output logic                 hActive,
  output logic                 vActive,
  output logic [3:0]           dotCol,
  output logic [4:0]           cellLine,
  output logic [ROW_IDX_W-1:0] charRow
);

  osdStrobe_t stb;

  osd_raster_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .hsyncIn  (hsyncIn),
    .vsyncIn  (vsyncIn),
    .hRunHigh (hRunHigh),
    .vClrHigh (vClrHigh),
    .stb      (stb)
  );

  osd_raster_dpath #(
    .COLS      (COLS),
    .ROWS      (ROWS),
    .POS_W     (POS_W),
    .H_CNT_W   (H_CNT_W),
    .V_CNT_W   (V_CNT_W),
    .ROW_IDX_W (ROW_IDX_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hStart   (hStart),
    .vStart   (vStart),
    .rowSize  (rowSize),
    .rowGap   (rowGap),
    .hActive  (hActive),
    .vActive  (vActive),
    .dotCol   (dotCol),
    .cellLine (cellLine),
    .charRow  (charRow)
  );

  assert_disable_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!hActive && !vActive))
    else $error("window active while disabled");

endmodule

// File: tb/osd_raster_timer_bench.sv
`timescale 1ns/1ps
module osd_raster_timer_bench;

  localparam int COLS_TB = 2;
  localparam int ROWS_TB = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic       hsyncIn = 1'b0;
  logic       vsyncIn = 1'b0;
  logic       hRunHigh = 1'b1;
  logic       vClrHigh = 1'b1;
  logic [5:0] hStart = '0;
  logic [5:0] vStart = '0;
  logic [1:0] rowSize = '0;
  logic [1:0] rowGap = '0;
  logic       hActive;
  logic       vActive;
  logic [3:0] dotCol;
  logic [4:0] cellLine;
  logic [1:0] charRow;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  osd_raster_timer #(.COLS(COLS_TB), .ROWS(ROWS_TB)) u_osd_raster_timer (
    .clk(clk), .rstN(rstN), .enable(enable), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .hRunHigh(hRunHigh), .vClrHigh(vClrHigh), .hStart(hStart), .vStart(vStart),
    .rowSize(rowSize), .rowGap(rowGap), .hActive(hActive), .vActive(vActive),
    .dotCol(dotCol), .cellLine(cellLine), .charRow(charRow)
  );

  // stimulus and expected result per horizontal vector
  typedef struct packed {
    logic [5:0]  hPos;
    logic [1:0]  sizeCode;
    logic        pol;
    logic [15:0] expFirst;   // 4*hPos+8
    logic [15:0] expWidth;   // COLS_TB*12*(sizeCode+1)
  } hVec_t;

  localparam hVec_t H_VECS [6] = '{
    '{6'd0,  2'd0, 1'b1, 16'd8,   16'd24},
    '{6'd1,  2'd1, 1'b1, 16'd12,  16'd48},
    '{6'd63, 2'd3, 1'b1, 16'd260, 16'd96},
    '{6'd10, 2'd2, 1'b0, 16'd48,  16'd72},
    '{6'd5,  2'd0, 1'b0, 16'd28,  16'd24},
    '{6'd32, 2'd1, 1'b1, 16'd136, 16'd48}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic resetFrame();
    vsyncIn = vClrHigh;
    repeat (4) tick();
    vsyncIn = !vClrHigh;
    repeat (4) tick();
  endtask

  task automatic measureH(input bit pol, input int sc, input int runLen,
                          output int first, output int width, output int dotErr);
    first = -1; width = 0; dotErr = 0;
    hsyncIn = pol;
    for (int n = 1; n <= runLen; n++) begin
      tick();
      if (hActive) begin
        if (first < 0) first = n;
        width++;
        if (int'(dotCol) != ((n - first) / sc) % 12) dotErr++;
      end else if (dotCol != 4'd0) begin
        dotErr++;
      end
    end
    hsyncIn = !pol;
    repeat (4) tick();
  endtask

  function automatic int vCode(int va, int ln, int rw);
    return va * 10000 + ln * 100 + rw;
  endfunction

  function automatic int vModel(int j, int sc, int gapL);
    int blk, row, r;
    if (j < 0) return 0;
    blk = 18 * sc + gapL;
    row = j / blk;
    r = j % blk;
    if (row < ROWS_TB && r < 18 * sc) return vCode(1, r / sc, row);
    return 0;
  endfunction

  task automatic lineOnce();
    hsyncIn = 1'b1; repeat (2) tick();
    hsyncIn = 1'b0; repeat (2) tick();
  endtask

  task automatic runFrame(input int vs, input int sizeCode, input int gapCode,
                          input bit clrHigh, input int nLines, input string tag);
    int errs, firstAct, firstExp, got, exp;
    hRunHigh = 1'b1; hsyncIn = 1'b0; vClrHigh = clrHigh;
    vStart = 6'(vs); rowSize = 2'(sizeCode); rowGap = 2'(gapCode);
    resetFrame();
    errs = 0; firstAct = 0; firstExp = 0;
    for (int p = 0; p < nLines; p++) begin
      lineOnce();
      got = vCode(int'(vActive), int'(cellLine), int'(charRow));
      exp = vModel(p - 4 * vs, sizeCode + 1, gapCode * 4);
      if (got != exp) begin
        if (errs == 0) begin firstAct = got; firstExp = exp; end
        errs++;
      end
    end
    check(errs == 0, tag, firstAct, firstExp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first, width, dotErr, got;
    // R1: reset state
    repeat (3) tick();
    check(!hActive && !vActive && dotCol == 0 && cellLine == 0 && charRow == 0,
          "R1 in reset", vCode(int'(vActive), int'(cellLine), int'(charRow)), 0);
    rstN = 1'b1;
    tick();
    check(!hActive && !vActive && dotCol == 0, "R1 after release", int'(hActive), 0);

    // horizontal vector table (R2, R3, R4, R12)
    for (int i = 0; i < 6; i++) begin
      hRunHigh = H_VECS[i].pol;
      hsyncIn = !H_VECS[i].pol;
      vClrHigh = 1'b1; vStart = '0; rowGap = '0;
      hStart = H_VECS[i].hPos;
      rowSize = H_VECS[i].sizeCode;
      resetFrame();
      measureH(H_VECS[i].pol, int'(H_VECS[i].sizeCode) + 1,
               int'(H_VECS[i].expFirst) + int'(H_VECS[i].expWidth) + 6,
               first, width, dotErr);
      check(first == int'(H_VECS[i].expFirst),
            H_VECS[i].pol ? "R2 start" : "R4 start low-run", first, int'(H_VECS[i].expFirst));
      check(width == int'(H_VECS[i].expWidth), "R3 width", width, int'(H_VECS[i].expWidth));
      check(dotErr == 0, "R3 R12 dotCol", dotErr, 0);
    end

    // R5: leaving the run level mid-window
    hRunHigh = 1'b1; hsyncIn = 1'b0; hStart = '0; rowSize = '0;
    resetFrame();
    hsyncIn = 1'b1;
    repeat (12) tick();
    check(hActive == 1'b1, "R5 active before cut", int'(hActive), 1);
    hsyncIn = 1'b0;
    repeat (2) tick();
    check(hActive == 1'b1, "R5 still active 2 edges after cut", int'(hActive), 1);
    tick();
    check(!hActive && dotCol == 0, "R5 cleared 3 edges after cut", int'(hActive), 0);
    repeat (4) tick();

    // vertical frames: R7 R6 R8 R9
    runFrame(0, 0, 0, 1'b1, 60, "R7 rows scale1");
    runFrame(3, 1, 1, 1'b0, 136, "R9 low clear, R8 gap4");
    runFrame(63, 3, 3, 1'b1, 510, "R6 start 252, R8 gap12");
    runFrame(2, 2, 2, 1'b1, 198, "R8 gap8 scale3");

    // R10: size change mid-row lands at the next row
    hRunHigh = 1'b1; hsyncIn = 1'b0; vClrHigh = 1'b1;
    vStart = '0; rowSize = 2'd0; rowGap = 2'd0;
    resetFrame();
    for (int p = 0; p < 54; p++) begin
      if (p == 5) rowSize = 2'd1;
      lineOnce();
      got = vCode(int'(vActive), int'(cellLine), int'(charRow));
      if (p == 17) check(got == vCode(1, 17, 0), "R10 row0 keeps scale1", got, vCode(1, 17, 0));
      if (p == 19) check(got == vCode(1, 0, 1), "R10 row1 scale2 line0", got, vCode(1, 0, 1));
      if (p == 20) check(got == vCode(1, 1, 1), "R10 row1 scale2 line1", got, vCode(1, 1, 1));
      if (p == 53) check(got == vCode(1, 17, 1), "R10 row1 last line", got, vCode(1, 17, 1));
    end

    // R11: disabled block ignores syncs
    enable = 1'b0;
    hStart = '0; rowSize = '0; vStart = '0;
    resetFrame();
    measureH(1'b1, 1, 60, first, width, dotErr);
    check(width == 0 && dotErr == 0, "R11 hActive while disabled", width, 0);
    check(!vActive && cellLine == 0 && charRow == 0, "R11 vActive while disabled",
          int'(vActive), 0);
    enable = 1'b1;
    resetFrame();
    measureH(1'b1, 1, 40, first, width, dotErr);
    check(first == 8, "R11 resumes after enable", first, 8);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule